// File: doc/BRIEF.md
# Bit-Clear Execute Slice with Operand Shifter

This block carries out the execute step of a 32-bit bit-clear instruction. It takes the decoded instruction word, the values already read for the first operand, the second operand and the shift-amount register, and the current N, Z, C and V flags. The second operand goes through a barrel shifter that also returns a carry-out. The result is the first operand ANDed with the bitwise inverse of the shifted value. A condition check against the incoming flags decides whether the instruction takes effect.

The outputs are registered, so results appear one clock after `issueValid`. A destination of register 15 sends the result to a PC-write output, and the register write port stays idle. The S bit then marks that PC write as an exception return. For any other destination, the S bit lets the result and the shifter carry update the flags, and V always keeps its old value. Register reading, fetch, exception handling and other opcodes are outside this block.

Top module: `bic_exec_unit`

## Requirements
- R1: One cycle after a clock edge with `issueValid` high, `outValid` is 1 and `result` equals `opnA & ~shifted`, where `shifted` is `opnB` after the selected shift. `rdIndex` equals instruction bits [15:12].
- R2: The condition field is instruction bits [31:28], tested against flags N=`flagsIn[3]`, Z=`flagsIn[2]`, C=`flagsIn[1]`, V=`flagsIn[0]`. The codes are: 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !C|Z, 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 Z|(N!=V), 14 and 15 always.
- R3: When the condition fails, `rdWrite`, `pcWrite` and `excReturn` are 0 and `flagsOut` equals the `flagsIn` that was issued.
- R4: With the S bit (instruction bit 20) set, a passing condition and a destination other than 15, `flagsOut` is {result[31], result==0, shifter carry, old V}. With S clear, `flagsOut` equals `flagsIn`.
- R5: With a passing condition, destination 15 sets `pcWrite` and clears `rdWrite`, and `flagsOut` equals `flagsIn`. `excReturn` equals the S bit. Any other destination sets `rdWrite` and clears `pcWrite`.
- R6: Bit 4 selects the shift form. 0 is immediate: amount in bits [11:7], type in bits [6:5], with 00 LSL, 01 LSR, 10 ASR and 11 ROR. 1 is register: amount from `shiftSrc`, type in bits [6:5]. In the register form, bit 7 must be 0. If bit 7 is 1, nothing is written and `flagsOut` equals `flagsIn`.
- R7: For immediate shifts, LSL by 0 passes the operand and the carry is the old C. LSR by 0 means a shift by 32, giving 0 with carry = operand bit 31. ASR by 0 gives 32 copies of bit 31 with carry = bit 31. Nonzero amounts shift normally, and the carry is the last bit shifted out.
- R8: Immediate type 11 with amount 0 is a one-bit right rotate. The old C enters bit 31 and the carry is the old bit 0.
- R9: In the register form, only `shiftSrc[7:0]` counts. An amount of 0 leaves the operand and C unchanged. LSL/LSR by exactly 32 gives 0 with carry = bit 0 or bit 31 respectively. LSL/LSR above 32 gives 0 with carry 0. ASR at 32 or more gives all sign bits with carry = sign. ROR uses the amount modulo 32, and a nonzero multiple of 32 leaves the operand unchanged with carry = bit 31.
- R10: After reset, `outValid`, `rdWrite`, `pcWrite`, `excReturn`, `result` and `flagsOut` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | Instruction and operands present this cycle |
| instrWord | input | 32 | Decoded instruction word |
| opnA | input | 32 | First operand value |
| opnB | input | 32 | Second operand value, shifted |
| shiftSrc | input | 32 | Shift-amount register value (register form) |
| flagsIn | input | 4 | Current flags {N,Z,C,V} |
| outValid | output | 1 | Outputs below belong to an issued instruction |
| result | output | 32 | Bit-clear result |
| rdIndex | output | 4 | Destination register index |
| rdWrite | output | 1 | Write `result` to register `rdIndex` |
| pcWrite | output | 1 | Write `result` to the program counter |
| excReturn | output | 1 | PC write is an exception return |
| flagsOut | output | 4 | Next flags {N,Z,C,V} |

## Verification
Two functions can meet in one cycle. One is the shifter-carry flag update. The other is the redirect of a register-15 destination to the PC output, which must stop that update. The bench provokes this by issuing S-set instructions with destination 15, using shifts (RRX, LSR by 32) whose carry differs from the incoming C. It judges the result by checking that `flagsOut` still matches the incoming flags while `pcWrite` and `excReturn` rise. The same clash is also run with a failing condition, where neither the PC write nor the flag update may happen.

// File: rtl/bic_pkg.sv
package bic_pkg;
  localparam int INSTR_W  = 32;
  localparam int AMT_W    = 8;
  localparam int FLAG_N   = 3;
  localparam int FLAG_Z   = 2;
  localparam int FLAG_C   = 1;
  localparam int FLAG_V   = 0;
  localparam logic [3:0] PC_INDEX = 4'hF;

  typedef enum logic [2:0] {
    SH_LSL, SH_LSR, SH_ASR, SH_ROR, SH_RRX
  } shKind_e;

  typedef struct packed {
    logic    condPass;
    logic    legal;
    logic    regWrite;
    logic    pcWrite;
    logic    excRet;
    logic    flagUpd;
    logic    regAmt;
    shKind_e kind;
  } ctrlStrobe_t;
endpackage

// File: rtl/bic_shifter.sv
module bic_shifter
  import bic_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  shKind_e          kind,
  input  logic [AMT_W-1:0] amt,
  input  logic [XLEN-1:0]  x,
  input  logic             cin,
  output logic [XLEN-1:0]  y,
  output logic             cout
);
  localparam int ROT_W = $clog2(XLEN);
  localparam logic [AMT_W-1:0] LIM    = AMT_W'(XLEN);
  localparam logic [AMT_W-1:0] LIMP1  = AMT_W'(XLEN + 1);

  logic [AMT_W-1:0]       logAmt;
  logic [AMT_W-1:0]       arAmt;
  logic [XLEN:0]          wideL;
  logic [XLEN:0]          wideR;
  logic signed [XLEN:0]   wideA;
  logic [2*XLEN-1:0]      dbl;
  logic [ROT_W-1:0]       rot;

  always_comb begin
    logAmt = (amt > LIM) ? LIMP1 : amt;
    arAmt  = (amt > LIM) ? LIM : amt;
    rot    = amt[ROT_W-1:0];
    wideL  = {1'b0, x} << logAmt;
    wideR  = {x, 1'b0} >> logAmt;
    wideA  = $signed({x, 1'b0}) >>> arAmt;
    dbl    = {x, x} >> rot;
  end

  always_comb begin
    y    = x;
    cout = cin;
    if (kind == SH_RRX) begin
      y    = {cin, x[XLEN-1:1]};
      cout = x[0];
    end else if (amt != '0) begin
      unique case (kind)
        SH_LSL: begin y = wideL[XLEN-1:0]; cout = wideL[XLEN]; end
        SH_LSR: begin y = wideR[XLEN:1];   cout = wideR[0];    end
        SH_ASR: begin y = wideA[XLEN:1];   cout = wideA[0];    end
        default: begin
          y    = dbl[XLEN-1:0];
          cout = dbl[XLEN-1];
        end
      endcase
    end
  end
endmodule

// File: rtl/bic_ctrl.sv
module bic_ctrl
  import bic_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [INSTR_W-1:0] instrWord,
  input  logic [3:0]         flagsIn,
  output ctrlStrobe_t        strobe,
  output logic [AMT_W-1:0]   immShamt
);
  logic [3:0] condCode;
  logic       sBit;
  logic [3:0] rdIdx;
  logic [4:0] imm5;
  logic [1:0] sType;
  logic       regForm;
  logic       nF, zF, cF, vF;
  logic       pass;
  logic       go;
  logic       toPc;

  assign condCode = instrWord[31:28];
  assign sBit     = instrWord[20];
  assign rdIdx    = instrWord[15:12];
  assign imm5     = instrWord[11:7];
  assign sType    = instrWord[6:5];
  assign regForm  = instrWord[4];
  assign nF = flagsIn[FLAG_N];
  assign zF = flagsIn[FLAG_Z];
  assign cF = flagsIn[FLAG_C];
  assign vF = flagsIn[FLAG_V];

  always_comb begin
    unique case (condCode)
      4'd0:  pass = zF;
      4'd1:  pass = !zF;
      4'd2:  pass = cF;
      4'd3:  pass = !cF;
      4'd4:  pass = nF;
      4'd5:  pass = !nF;
      4'd6:  pass = vF;
      4'd7:  pass = !vF;
      4'd8:  pass = cF && !zF;
      4'd9:  pass = !cF || zF;
      4'd10: pass = (nF == vF);
      4'd11: pass = (nF != vF);
      4'd12: pass = !zF && (nF == vF);
      4'd13: pass = zF || (nF != vF);
      default: pass = 1'b1;
    endcase
  end

  always_comb begin
    toPc = (rdIdx == PC_INDEX);
    go   = pass && !(regForm && instrWord[7]);

    strobe.condPass = pass;
    strobe.legal    = !(regForm && instrWord[7]);
    strobe.regWrite = go && !toPc;
    strobe.pcWrite  = go && toPc;
    strobe.excRet   = go && toPc && sBit;
    strobe.flagUpd  = go && !toPc && sBit;
    strobe.regAmt   = regForm;

    unique case (sType)
      2'b00: strobe.kind = SH_LSL;
      2'b01: strobe.kind = SH_LSR;
      2'b10: strobe.kind = SH_ASR;
      default: strobe.kind = (!regForm && imm5 == 5'd0) ? SH_RRX : SH_ROR;
    endcase

    if ((sType == 2'b01 || sType == 2'b10) && imm5 == 5'd0)
      immShamt = AMT_W'(XLEN);
    else
      immShamt = AMT_W'(imm5);
  end
endmodule

// File: rtl/bic_datapath.sv
module bic_datapath
  import bic_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic [AMT_W-1:0] immShamt,
  input  logic [XLEN-1:0]  opnA,
  input  logic [XLEN-1:0]  opnB,
  input  logic [XLEN-1:0]  shiftSrc,
  input  logic [3:0]       flagsIn,
  output logic [XLEN-1:0]  result,
  output logic [3:0]       nextFlags
);
  logic [AMT_W-1:0] amtSel;
  logic [XLEN-1:0]  shOut;
  logic             shCarry;

  assign amtSel = strobe.regAmt ? shiftSrc[AMT_W-1:0] : immShamt;

  bic_shifter #(.XLEN(XLEN)) i_shifter (
    .kind (strobe.kind),
    .amt  (amtSel),
    .x    (opnB),
    .cin  (flagsIn[FLAG_C]),
    .y    (shOut),
    .cout (shCarry)
  );

  always_comb begin
    result    = opnA & ~shOut;
    nextFlags = flagsIn;
    if (strobe.flagUpd) begin
      nextFlags[FLAG_N] = result[XLEN-1];
      nextFlags[FLAG_Z] = (result == '0);
      nextFlags[FLAG_C] = shCarry;
    end
  end

  // R8: extend-rotate brings the old carry into the top bit and bit 0 out
  p_rrx_fills_top_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.kind == SH_RRX) |-> (shOut[XLEN-1] == flagsIn[FLAG_C]) && (shCarry == opnB[0]));

  // R9: a register amount of zero leaves operand and carry untouched
  p_zero_reg_amt_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.regAmt && shiftSrc[AMT_W-1:0] == '0) |-> (shOut == opnB) && (shCarry == flagsIn[FLAG_C]));
endmodule

// File: rtl/bic_exec_unit.sv
module bic_exec_unit
  import bic_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               issueValid,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic [XLEN-1:0]    opnA,
  input  logic [XLEN-1:0]    opnB,
  input  logic [XLEN-1:0]    shiftSrc,
  input  logic [3:0]         flagsIn,
  output logic               outValid,
  output logic [XLEN-1:0]    result,
  output logic [3:0]         rdIndex,
  output logic               rdWrite,
  output logic               pcWrite,
  output logic               excReturn,
  output logic [3:0]         flagsOut
);
  ctrlStrobe_t      strobe;
  logic [AMT_W-1:0] immShamt;
  logic [XLEN-1:0]  dpResult;
  logic [3:0]       dpFlags;

  bic_ctrl #(.XLEN(XLEN)) i_ctrl (
    .instrWord (instrWord),
    .flagsIn   (flagsIn),
    .strobe    (strobe),
    .immShamt  (immShamt)
  );

  bic_datapath #(.XLEN(XLEN)) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .immShamt  (immShamt),
    .opnA      (opnA),
    .opnB      (opnB),
    .shiftSrc  (shiftSrc),
    .flagsIn   (flagsIn),
    .result    (dpResult),
    .nextFlags (dpFlags)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      result    <= '0;
      rdIndex   <= '0;
      rdWrite   <= 1'b0;
      pcWrite   <= 1'b0;
      excReturn <= 1'b0;
      flagsOut  <= '0;
    end else begin
      outValid  <= issueValid;
      rdWrite   <= issueValid && strobe.regWrite;
      pcWrite   <= issueValid && strobe.pcWrite;
      excReturn <= issueValid && strobe.excRet;
      if (issueValid) begin
        result   <= dpResult;
        rdIndex  <= instrWord[15:12];
        flagsOut <= dpFlags;
      end
    end
  end

  // R5: exception return only rides on a PC write
  p_excret_needs_pc_r5: assert property (@(posedge clk) disable iff (!rstN)
    excReturn |-> pcWrite);

  // R5: one write target at most
  p_one_target_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rdWrite, pcWrite}));

  // R4: overflow flag passes through
  p_v_kept_r4: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |=> flagsOut[FLAG_V] == $past(flagsIn[FLAG_V]));

  // R3: failed condition writes nothing and holds flags
  p_cond_fail_holds_r3: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && !strobe.condPass) |=> (flagsOut == $past(flagsIn)) && !rdWrite && !pcWrite);
endmodule

// File: tb/test_bic_exec_unit.sv
module test_bic_exec_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        issueValid = 1'b0;
  logic [31:0] instrWord = '0;
  logic [31:0] opnA = '0, opnB = '0, shiftSrc = '0;
  logic [3:0]  flagsIn = '0;
  logic        outValid, rdWrite, pcWrite, excReturn;
  logic [31:0] result;
  logic [3:0]  rdIndex, flagsOut;

  int nVec = 0;
  int nBad = 0;

  always #5 clk = ~clk;

  bic_exec_unit i_bic_exec_unit (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .instrWord(instrWord),
    .opnA(opnA), .opnB(opnB), .shiftSrc(shiftSrc), .flagsIn(flagsIn),
    .outValid(outValid), .result(result), .rdIndex(rdIndex), .rdWrite(rdWrite),
    .pcWrite(pcWrite), .excReturn(excReturn), .flagsOut(flagsOut)
  );

  function automatic logic condOk(input logic [3:0] c, input logic [3:0] f);
    logic n, z, cy, v;
    {n, z, cy, v} = f;
    case (c)
      0: return z;              1: return !z;
      2: return cy;             3: return !cy;
      4: return n;              5: return !n;
      6: return v;              7: return !v;
      8: return cy && !z;       9: return !cy || z;
      10: return n == v;        11: return n != v;
      12: return !z && n == v;  13: return z || n != v;
      default: return 1'b1;
    endcase
  endfunction

  // bit-by-bit reference shifter; typ 4 = extend-rotate
  task automatic refShift(input int typ, input int amt, input logic [31:0] x,
                          input logic cin, output logic [31:0] y, output logic c);
    y = x; c = cin;
    if (typ == 4) begin
      c = x[0]; y = {cin, x[31:1]};
      return;
    end
    for (int i = 0; i < amt; i++) begin
      case (typ)
        0: begin c = y[31]; y = y << 1; end
        1: begin c = y[0];  y = y >> 1; end
        2: begin c = y[0];  y = {y[31], y[31:1]}; end
        default: begin c = y[0]; y = {y[0], y[31:1]}; end
      endcase
    end
  endtask

  function automatic logic [31:0] mkImm(input logic [3:0] cnd, input logic s, input logic [3:0] rd,
                                        input logic [4:0] imm, input logic [1:0] typ);
    return {cnd, 7'b0001110, s, 4'd1, rd, imm, typ, 1'b0, 4'd2};
  endfunction

  function automatic logic [31:0] mkReg(input logic [3:0] cnd, input logic s, input logic [3:0] rd,
                                        input logic b7, input logic [1:0] typ);
    return {cnd, 7'b0001110, s, 4'd1, rd, 4'd3, b7, typ, 1'b1, 4'd2};
  endfunction

  task automatic applyVec(input string req, input logic [31:0] ins, input logic [31:0] a,
                          input logic [31:0] b, input logic [31:0] s, input logic [3:0] fl);
    logic pass, legal, sb, isPc;
    logic [3:0] rd;
    int typ, amt;
    logic [31:0] sh, expRes;
    logic cy;
    logic expRw, expPw, expEx;
    logic [3:0] expFl;
    pass  = condOk(ins[31:28], fl);
    legal = !(ins[4] && ins[7]);
    sb    = ins[20];
    rd    = ins[15:12];
    isPc  = (rd == 4'hF);
    typ   = int'(ins[6:5]);
    if (!ins[4]) begin
      amt = int'(ins[11:7]);
      if ((typ == 1 || typ == 2) && amt == 0) amt = 32;
      if (typ == 3 && amt == 0) typ = 4;
    end else begin
      amt = int'(s[7:0]);
    end
    refShift(typ, amt, b, fl[1], sh, cy);
    expRes = a & ~sh;
    expRw  = pass && legal && !isPc;
    expPw  = pass && legal && isPc;
    expEx  = expPw && sb;
    expFl  = (pass && legal && sb && !isPc) ? {expRes[31], expRes == 0, cy, fl[0]} : fl;

    @(negedge clk);
    instrWord = ins; opnA = a; opnB = b; shiftSrc = s; flagsIn = fl; issueValid = 1'b1;
    @(negedge clk);
    issueValid = 1'b0;
    nVec++;
    if (outValid !== 1'b1 || rdIndex !== rd || rdWrite !== expRw || pcWrite !== expPw ||
        excReturn !== expEx || flagsOut !== expFl || (legal && result !== expRes)) begin
      nBad++;
      $display("FAIL %s ins=%h: got v=%b res=%h rd=%h rw=%b pw=%b ex=%b fl=%b; want v=1 res=%h rd=%h rw=%b pw=%b ex=%b fl=%b",
               req, ins, outValid, result, rdIndex, rdWrite, pcWrite, excReturn, flagsOut,
               expRes, rd, expRw, expPw, expEx, expFl);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: got timeout, want completion");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    logic [31:0] ops [4];
    ops[0] = 32'h8000_0001; ops[1] = 32'hFFFF_FFFF; ops[2] = 32'h0000_0000; ops[3] = 32'h7A5C_3E19;
    repeat (3) @(negedge clk);
    // R10: reset state
    nVec++;
    if (outValid !== 0 || rdWrite !== 0 || pcWrite !== 0 || excReturn !== 0 ||
        result !== 0 || flagsOut !== 0) begin
      nBad++;
      $display("FAIL R10: got v=%b rw=%b pw=%b ex=%b res=%h fl=%b, want all 0",
               outValid, rdWrite, pcWrite, excReturn, result, flagsOut);
    end
    rstN = 1'b1;

    // R2 and R3: every condition against every flag combination
    for (int c = 0; c < 16; c++)
      for (int f = 0; f < 16; f++)
        applyVec("R2/R3", mkImm(4'(c), 1'b1, 4'd2, 5'd0, 2'b00), 32'hF0F0_1234, 32'h0FF0_0000, 0, 4'(f));

    // R7, R8: all immediate types and amounts
    for (int t = 0; t < 4; t++)
      for (int im = 0; im < 32; im++)
        for (int o = 0; o < 4; o++)
          for (int ci = 0; ci < 2; ci++)
            applyVec((t == 3 && im == 0) ? "R8" : "R7", mkImm(4'hE, 1'b1, 4'd1, 5'(im), 2'(t)),
                     ~ops[(o + 1) % 4] | $urandom, ops[o], 0, {2'b00, 1'(ci), 1'b1});

    // R9: register amounts, upper bits of the amount register random
    for (int t = 0; t < 4; t++)
      for (int k = 0; k < 48; k++) begin
        int amt;
        amt = (k < 41) ? k : (k == 41 ? 63 : k == 42 ? 64 : k == 43 ? 96 : k == 44 ? 127 :
                              k == 45 ? 128 : k == 46 ? 224 : 255);
        for (int o = 0; o < 4; o++)
          for (int ci = 0; ci < 2; ci++)
            applyVec("R9", mkReg(4'hE, 1'b1, 4'd4, 1'b0, 2'(t)), 32'hFFFF_FFFF, ops[o],
                     {$urandom_range(0, 32'hFF_FFFF) , 8'(amt)} , {1'b0, 1'(ci), 1'b0, 1'(o)});
      end

    // R5: destination 15 with S, clashing with shifter carry, condition pass/fail
    for (int s = 0; s < 2; s++)
      for (int z = 0; z < 2; z++) begin
        applyVec("R5", mkImm(4'h0, 1'(s), 4'hF, 5'd0, 2'b11), 32'hFFFF_0000, 32'h0000_0001, 0, {1'b0, 1'(z), 2'b01});
        applyVec("R5", mkImm(4'h0, 1'(s), 4'hF, 5'd0, 2'b01), 32'h1234_5678, 32'h8000_0000, 0, {1'b1, 1'(z), 2'b00});
        applyVec("R5", mkImm(4'hE, 1'(s), 4'(14 + z), 5'd3, 2'b10), 32'hCAFE_F00D, 32'h8765_4321, 0, 4'b0110);
      end

    // R4: S clear keeps flags for ordinary destinations
    for (int rd = 0; rd < 15; rd++)
      applyVec("R4", mkReg(4'hF, 1'b0, 4'(rd), 1'b0, 2'(rd)), 32'h0000_0000, 32'h5555_AAAA, 32'(rd * 3), 4'(rd));

    // R6: register form with bit 7 set has no effect
    for (int f = 0; f < 16; f++)
      applyVec("R6", mkReg(4'hE, 1'b1, 4'(f), 1'b1, 2'(f)), 32'hFFFF_FFFF, 32'h0F0F_0F0F, 32'd4, 4'(f));

    // R1: random words through every field
    for (int i = 0; i < 400; i++)
      applyVec("R1", $urandom, $urandom, $urandom, $urandom, 4'($urandom));

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule